// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned 8-bit operands and returns the low 8 bits of the product. It retires one multiplier bit per iteration. In each iteration the adder forms the sum of the accumulator and the multiplicand, and that sum is kept only when the current low bit of the multiplier is 1. The multiplier then moves one place toward bit 0, and the multiplicand moves one place toward the top bit.

Both operand registers are filled through one shared data bus. The bus has four sources: the two input ports, used while the operands are set up, and the shifted copies of the two operand registers, used during computation. The controller selects the source with one enable per source, and it never enables two sources in the same cycle.

A `start` pulse begins a multiply, and `ready` then reports that the result is valid. The result stays on `product` until the next accepted start.

Top module: `shadd_mult`

## Requirements
- R1: When `ready` is high, `product` equals (opX * opY) mod 256 for the operands that were presented during the multiply.
- R2: `ready` first reads high 25 rising edges after the edge that samples `start`, for every operand value, including X = 0 and X = 255.
- R3: After reset, `ready` is 0 and `product` is 0.
- R4: A `start` pulse while a multiply is in progress is ignored. The running result and its latency are unchanged, even if the operand ports change at the same time.
- R5: Once `ready` is high, it stays high, and `product` holds its value, until the next `start`, whatever the operand ports do.
- R6: The accumulator keeps its value in any accumulate step whose multiplier low bit is 0. A multiply with X = 0 gives 0 for any Y.
- R7: At most one of the four bus source enables is active in any cycle.
- R8: Each accepted start first clears all registers, then loads X from the bus, then loads Y from the bus. No earlier result carries over into the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiply when idle or done |
| opX | input | 8 | Multiplier operand |
| opY | input | 8 | Multiplicand operand |
| product | output | 8 | Low 8 bits of X*Y |
| ready | output | 1 | Result valid; held until the next start |

## Verification
Two functions can coincide in one cycle. A new `start` can arrive while an iteration is still shifting and accumulating. The bench provokes this by pulsing `start` partway through a multiply, with different values on the operand ports in that same cycle. It then judges the outcome: the result must still be the product of the original operands, and `ready` must rise at the unchanged 25-edge point. A second coincidence is a start that lands in the done state. The bench provokes it by issuing one multiply right after another, and it judges that a zero-result multiply keeps nothing from the previous one.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // Index of each bus source within the enable vector
  localparam int SRC_IN_X  = 0;
  localparam int SRC_IN_Y  = 1;
  localparam int SRC_SHR_X = 2;
  localparam int SRC_SHL_Y = 3;
  localparam int NUM_SRC   = 4;

  typedef struct packed {
    logic               clearAll;
    logic               loadX;
    logic               loadY;
    logic               accum;
    logic [NUM_SRC-1:0] drvEn;
  } strobe_t;

endpackage

// File: rtl/shadd_datapath.sv
module shadd_datapath
  import mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W-1:0] product,
  output logic         xLsb
);

  logic [W-1:0] xReg, yReg, prodReg;
  logic [W-1:0] xShr, yShl, sum, dataBus;

  // Shifts are pure wiring
  assign xShr = {1'b0, xReg[W-1:1]};
  assign yShl = {yReg[W-2:0], 1'b0};

  // Speculative add, truncated to W bits
  assign sum = prodReg + yReg;

  // Shared bus: AND-OR of sources under their enables
  always_comb begin
    dataBus = '0;
    if (strobe.drvEn[SRC_IN_X])  dataBus = dataBus | opX;
    if (strobe.drvEn[SRC_IN_Y])  dataBus = dataBus | opY;
    if (strobe.drvEn[SRC_SHR_X]) dataBus = dataBus | xShr;
    if (strobe.drvEn[SRC_SHL_Y]) dataBus = dataBus | yShl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      prodReg <= '0;
    end else if (strobe.clearAll) begin
      xReg    <= '0;
      yReg    <= '0;
      prodReg <= '0;
    end else begin
      if (strobe.loadX) xReg <= dataBus;
      if (strobe.loadY) yReg <= dataBus;
      if (strobe.accum && xReg[0]) prodReg <= sum;
    end
  end

  assign product = prodReg;
  assign xLsb    = xReg[0];

endmodule

// File: rtl/shadd_control.sv
module shadd_control
  import mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe,
  output logic    ready
);

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_LOAD_X, ST_LOAD_Y,
    ST_ACCUM, ST_SHIFT_X, ST_SHIFT_Y, ST_DONE
  } state_t;

  state_t           state, nextState;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE, ST_DONE: if (start) nextState = ST_CLEAR;
      ST_CLEAR:   nextState = ST_LOAD_X;
      ST_LOAD_X:  nextState = ST_LOAD_Y;
      ST_LOAD_Y:  nextState = ST_ACCUM;
      ST_ACCUM:   nextState = (iterCnt == LAST_ITER) ? ST_DONE : ST_SHIFT_X;
      ST_SHIFT_X: nextState = ST_SHIFT_Y;
      ST_SHIFT_Y: nextState = ST_ACCUM;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_CLEAR)      iterCnt <= '0;
      else if (state == ST_ACCUM) iterCnt <= iterCnt + 1'b1;
    end
  end

  // One source enable per bus phase; capture in the same phase
  always_comb begin
    strobe = '0;
    case (state)
      ST_CLEAR:   strobe.clearAll = 1'b1;
      ST_LOAD_X:  begin strobe.drvEn[SRC_IN_X]  = 1'b1; strobe.loadX = 1'b1; end
      ST_LOAD_Y:  begin strobe.drvEn[SRC_IN_Y]  = 1'b1; strobe.loadY = 1'b1; end
      ST_ACCUM:   strobe.accum = 1'b1;
      ST_SHIFT_X: begin strobe.drvEn[SRC_SHR_X] = 1'b1; strobe.loadX = 1'b1; end
      ST_SHIFT_Y: begin strobe.drvEn[SRC_SHL_Y] = 1'b1; strobe.loadY = 1'b1; end
      default:    ;
    endcase
  end

  assign ready = (state == ST_DONE);

endmodule

// File: rtl/shadd_mult.sv
module shadd_mult
  import mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W-1:0] product,
  output logic         ready
);

  strobe_t strobe;
  logic    xLsb;

  shadd_control #(.W(W)) i_control (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .ready (ready)
  );

  shadd_datapath #(.W(W)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opX    (opX),
    .opY    (opY),
    .product(product),
    .xLsb   (xLsb)
  );

endmodule

// File: rtl/shadd_mult_chk.sv
module shadd_mult_chk
  import mult_pkg::*;
#(
  parameter int W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               ready,
  input logic [W-1:0]       product,
  input logic [NUM_SRC-1:0] drvEn,
  input logic               accEn,
  input logic               loadX,
  input logic               loadY,
  input logic               xLsb
);

  // R7: never two bus sources at once
  a_r7_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(drvEn));

  // R7: every register capture has exactly one source on the bus
  a_r7_load_has_source: assert property (@(posedge clk) disable iff (!rstN)
    (loadX || loadY) |-> $countones(drvEn) == 1);

  // R5: ready held until a start
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !start) |=> ready);

  // R5: result stable while done
  a_r5_product_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !start) |=> $stable(product));

  // R6: no commit when the multiplier low bit is clear
  a_r6_skip_commit: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !xLsb) |=> $stable(product));

endmodule

bind shadd_mult shadd_mult_chk #(.W(W)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .ready  (ready),
  .product(product),
  .drvEn  (strobe.drvEn),
  .accEn  (strobe.accum),
  .loadX  (strobe.loadX),
  .loadY  (strobe.loadY),
  .xLsb   (xLsb)
);

// File: tb/test_shadd_mult.sv
module test_shadd_mult;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int LATENCY    = 3 * W + 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opX = '0;
  logic [W-1:0] opY = '0;
  logic [W-1:0] product;
  logic         ready;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shadd_mult #(.W(W)) i_shadd_mult (
    .clk(clk), .rstN(rstN), .start(start),
    .opX(opX), .opY(opY), .product(product), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] yPick(input int i);
    case (i)
      0: return 8'd0;    1: return 8'd1;    2: return 8'd2;    3: return 8'd3;
      4: return 8'd5;    5: return 8'd7;    6: return 8'd15;   7: return 8'd16;
      8: return 8'd85;   9: return 8'd99;   10: return 8'd127; 11: return 8'd128;
      12: return 8'd170; 13: return 8'd200; 14: return 8'd254; default: return 8'd255;
    endcase
  endfunction

  // Pulse start at a negedge; measure edges after the sampling edge until ready
  task automatic runMul(input logic [W-1:0] x, input logic [W-1:0] y,
                        input int midStartAt, output int lat);
    @(negedge clk);
    opX = x; opY = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!ready && lat < 4 * LATENCY) begin
      @(negedge clk);
      lat++;
      if (lat == midStartAt) begin
        opX = ~x; opY = y + 8'd9; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 ready", int'(ready), 0);
    check("R3 product", int'(product), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 and R6: latency independent of X, X=0 gives 0
    runMul(8'd0, 8'd201, 0, lat);
    check("R2 latency x=0", lat, LATENCY);
    check("R6 x=0", int'(product), 0);
    runMul(8'd255, 8'd255, 0, lat);
    check("R2 latency x=255", lat, LATENCY);
    check("R1 255*255", int'(product), (255 * 255) % 256);

    // R8: back-to-back start from done; no carry-over
    runMul(8'd0, 8'd77, 0, lat);
    check("R8 cleared", int'(product), 0);

    // R5: hold while done, operand ports moving
    runMul(8'd13, 8'd11, 0, lat);
    check("R1 13*11", int'(product), 143);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      opX = 8'(k * 37); opY = 8'(k * 91 + 3);
    end
    check("R5 ready held", int'(ready), 1);
    check("R5 product held", int'(product), 143);

    // R4: start during computation, with changed operands
    runMul(8'd13, 8'd11, 10, lat);
    check("R4 latency", lat, LATENCY);
    check("R4 result", int'(product), 143);
    runMul(8'd6, 8'd250, 20, lat);
    check("R4 late start", int'(product), (6 * 250) % 256);

    // R1 and R2: sweep all X against a set of Y values
    for (int x = 0; x < 256; x++) begin
      for (int j = 0; j < 16; j++) begin
        runMul(8'(x), yPick(j), 0, lat);
        check("R1 sweep", int'(product), (x * int'(yPick(j))) % 256);
        if (lat != LATENCY) check("R2 sweep latency", lat, LATENCY);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule